// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Aggregator

This block gathers the interrupt sources of a two-channel serial controller and folds them into one interrupt line. Each channel (index 0 is channel A, index 1 is channel B) delivers set and clear pulses for a receive-pending flag and a transmit-pending flag. It also delivers a break-detect pulse with its own clear, and three enable bits. Every channel's pending information is collected in one shared status byte, `pend_stat`. That byte belongs to channel A and is read there for both channels.

Inside each channel a three-state machine chooses which source the status byte shows. The states are `SRC_IDLE` (nothing pending), `SRC_SHOW_RX` (receive pending and shown) and `SRC_SHOW_TX` (only transmit pending and shown). The named transitions are:

- *arrive-rx*: IDLE or SHOW_TX to SHOW_RX.
- *arrive-tx*: IDLE to SHOW_TX.
- *reassert-tx*: SHOW_RX to SHOW_TX, taken when receive clears while transmit is still pending.
- *drain*: SHOW_RX or SHOW_TX to IDLE.

Receive outranks transmit, so a pending transmit stays hidden until receive is cleared. The interrupt output is registered. It is the OR of both channels' enabled conditions, taken one clock after the flags change.

Top module: `irq_aggregator`

## Requirements
- R1: While `rst_n` is low and after its release, `pend_stat`, `brk_stat` and `irq` are all zero.
- R2: A receive set pulse makes the receive bit of that channel read 1 in `pend_stat` after the next clock edge. Channel A's receive bit is bit 0 and channel B's is bit 3.
- R3: A transmit set pulse makes the transmit bit of that channel read 1 in `pend_stat` after the next clock edge, as long as receive is not pending on that channel. Channel A's transmit bit is bit 1 and channel B's is bit 4. Bits 7:6 always read 0.
- R4: When receive and transmit are both pending on one channel, only that channel's receive bit reads 1 and its transmit bit reads 0.
- R5: Clearing receive while transmit is still pending makes the transmit bit read 1 after the same edge. Clearing transmit while receive is pending leaves the receive bit at 1.
- R6: A break-detect pulse sets `brk_stat[ch]` and the channel's break bit in `pend_stat` (bit 2 for A, bit 5 for B). Both stay set until a break-clear pulse arrives.
- R7: A set pulse and a clear pulse for the same flag in the same cycle leave the flag set.
- R8: `irq` is 1 when either channel has (rx enable and receive pending), (tx enable and transmit pending, even while hidden by receive), or (break enable and break pending).
- R9: `irq` is a register. After a stimulus pulse it changes one edge later than `pend_stat`.
- R10: The enable bits have no effect on `pend_stat` or `brk_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_set | input | 2 | Receive-pending set pulse per channel |
| rx_clr | input | 2 | Receive-pending clear pulse per channel |
| tx_set | input | 2 | Transmit-pending set pulse per channel |
| tx_clr | input | 2 | Transmit-pending clear pulse per channel |
| brk_det | input | 2 | Break detected pulse per channel |
| brk_clr | input | 2 | Break status clear pulse per channel |
| rx_ie | input | 2 | Receive interrupt enable per channel |
| tx_ie | input | 2 | Transmit interrupt enable per channel |
| ext_ie | input | 2 | Break interrupt enable per channel |
| pend_stat | output | 8 | Shared pending status byte, read through channel A |
| brk_stat | output | 2 | Break status bit per channel |
| irq | output | 1 | Registered combined interrupt request |

## Verification
Pulses are sampled at a rising edge, and `pend_stat` and `brk_stat` show the result right after that edge. `irq` follows one edge later. Each stimulus is driven at a falling edge. `pend_stat` is compared at the falling edge after the first rising edge. The pulses are then dropped while the enables are held, and `irq` is compared at the following falling edge. A directed test checks that `irq` has not yet moved at the first sample point, which confirms the extra register stage.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NCH     = 2;
    localparam int FIELD_W = 3;
    localparam int STAT_W  = 8;
    localparam int F_RX    = 0;
    localparam int F_TX    = 1;
    localparam int F_BRK   = 2;

    typedef enum logic [1:0] {
        SRC_IDLE    = 2'd0,
        SRC_SHOW_RX = 2'd1,
        SRC_SHOW_TX = 2'd2
    } src_state_e;
endpackage

// File: rtl/irq_chan_src.sv
module irq_chan_src
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_set,
    input  logic rx_clr,
    input  logic tx_set,
    input  logic tx_clr,
    input  logic brk_det,
    input  logic brk_clr,
    input  logic rx_ie,
    input  logic tx_ie,
    input  logic ext_ie,
    output logic show_rx,
    output logic show_tx,
    output logic brk_pend,
    output logic cond
);
    src_state_e state, state_nx;
    logic rx_pend, tx_pend;
    logic rx_nx, tx_nx, brk_nx;

    // set beats clear when both arrive together
    always_comb begin
        rx_nx  = rx_set  | (rx_pend  & ~rx_clr);
        tx_nx  = tx_set  | (tx_pend  & ~tx_clr);
        brk_nx = brk_det | (brk_pend & ~brk_clr);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SRC_IDLE: begin
                if (rx_nx)      state_nx = SRC_SHOW_RX;   // arrive-rx
                else if (tx_nx) state_nx = SRC_SHOW_TX;   // arrive-tx
            end
            SRC_SHOW_RX: begin
                if (!rx_nx) begin
                    if (tx_nx) state_nx = SRC_SHOW_TX;    // reassert-tx
                    else       state_nx = SRC_IDLE;       // drain
                end
            end
            SRC_SHOW_TX: begin
                if (rx_nx)       state_nx = SRC_SHOW_RX;  // arrive-rx
                else if (!tx_nx) state_nx = SRC_IDLE;     // drain
            end
            default: state_nx = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SRC_IDLE;
            rx_pend  <= 1'b0;
            tx_pend  <= 1'b0;
            brk_pend <= 1'b0;
        end else begin
            state    <= state_nx;
            rx_pend  <= rx_nx;
            tx_pend  <= tx_nx;
            brk_pend <= brk_nx;
        end
    end

    always_comb begin
        show_rx = (state == SRC_SHOW_RX);
        show_tx = (state == SRC_SHOW_TX);
        cond    = (rx_ie & rx_pend) | (tx_ie & tx_pend) | (ext_ie & brk_pend);
    end

    // R4
    rx_over_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SRC_SHOW_TX) |-> !rx_pend);
    // R5
    tx_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SRC_SHOW_RX && rx_clr && !rx_set && tx_pend && !tx_clr)
        |=> (state == SRC_SHOW_TX));
    // R6
    brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pend && !brk_clr) |=> brk_pend);
    // R7
    rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> show_rx);
endmodule

// File: rtl/irq_merge.sv
module irq_merge
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    show_rx,
    input  logic [NCH-1:0]    show_tx,
    input  logic [NCH-1:0]    brk_pend,
    input  logic [NCH-1:0]    cond,
    output logic [STAT_W-1:0] pend_stat,
    output logic              irq
);
    localparam int USED_W = NCH * FIELD_W;

    logic [USED_W-1:0] packed_bits;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_field
        always_comb begin
            packed_bits[ch*FIELD_W + F_RX]  = show_rx[ch];
            packed_bits[ch*FIELD_W + F_TX]  = show_tx[ch];
            packed_bits[ch*FIELD_W + F_BRK] = brk_pend[ch];
        end

        // R4
        one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({pend_stat[ch*FIELD_W + F_RX], pend_stat[ch*FIELD_W + F_TX]}));
    end

    always_comb begin
        pend_stat = '0;
        pend_stat[USED_W-1:0] = packed_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |cond;
    end

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cond) |=> irq);
    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|cond) |=> !irq);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    rx_set,
    input  logic [NCH-1:0]    rx_clr,
    input  logic [NCH-1:0]    tx_set,
    input  logic [NCH-1:0]    tx_clr,
    input  logic [NCH-1:0]    brk_det,
    input  logic [NCH-1:0]    brk_clr,
    input  logic [NCH-1:0]    rx_ie,
    input  logic [NCH-1:0]    tx_ie,
    input  logic [NCH-1:0]    ext_ie,
    output logic [STAT_W-1:0] pend_stat,
    output logic [NCH-1:0]    brk_stat,
    output logic              irq
);
    logic [NCH-1:0] show_rx, show_tx, cond;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        irq_chan_src u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .rx_set   (rx_set[ch]),
            .rx_clr   (rx_clr[ch]),
            .tx_set   (tx_set[ch]),
            .tx_clr   (tx_clr[ch]),
            .brk_det  (brk_det[ch]),
            .brk_clr  (brk_clr[ch]),
            .rx_ie    (rx_ie[ch]),
            .tx_ie    (tx_ie[ch]),
            .ext_ie   (ext_ie[ch]),
            .show_rx  (show_rx[ch]),
            .show_tx  (show_tx[ch]),
            .brk_pend (brk_stat[ch]),
            .cond     (cond[ch])
        );
    end

    irq_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .show_rx   (show_rx),
        .show_tx   (show_tx),
        .brk_pend  (brk_stat),
        .cond      (cond),
        .pend_stat (pend_stat),
        .irq       (irq)
    );

    // R6
    brk_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|brk_det) |=> ((brk_stat & $past(brk_det)) == $past(brk_det)));
endmodule

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] rx_set, rx_clr, tx_set, tx_clr, brk_det, brk_clr;
    logic [1:0] rx_ie, tx_ie, ext_ie;
    logic [7:0] pend_stat;
    logic [1:0] brk_stat;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n),
        .rx_set(rx_set), .rx_clr(rx_clr), .tx_set(tx_set), .tx_clr(tx_clr),
        .brk_det(brk_det), .brk_clr(brk_clr),
        .rx_ie(rx_ie), .tx_ie(tx_ie), .ext_ie(ext_ie),
        .pend_stat(pend_stat), .brk_stat(brk_stat), .irq(irq)
    );

    // {rx_set, rx_clr, tx_set, tx_clr, brk_det, brk_clr, rx_ie, tx_ie, ext_ie, exp_pend, exp_irq}
    localparam int NV = 17;
    localparam logic [26:0] VEC [NV] = '{
        {2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,8'h01,1'b0}, // R2 A rx
        {2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,2'b00,2'b00,8'h01,1'b1}, // R8 enable
        {2'b00,2'b00,2'b01,2'b00,2'b00,2'b00,2'b01,2'b00,2'b00,8'h01,1'b1}, // R4 tx hidden
        {2'b00,2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,8'h02,1'b0}, // R5 reassert
        {2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,2'b00,8'h02,1'b1}, // R3 A tx
        {2'b10,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,8'h0A,1'b0}, // R2 B rx
        {2'b00,2'b00,2'b10,2'b00,2'b00,2'b00,2'b10,2'b00,2'b00,8'h0A,1'b1}, // R4 B
        {2'b00,2'b00,2'b00,2'b10,2'b00,2'b00,2'b10,2'b00,2'b00,8'h0A,1'b1}, // R5 converse
        {2'b00,2'b10,2'b00,2'b00,2'b00,2'b00,2'b00,2'b10,2'b00,8'h02,1'b0}, // R10
        {2'b00,2'b00,2'b00,2'b00,2'b01,2'b00,2'b00,2'b00,2'b00,8'h06,1'b0}, // R6 A brk
        {2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,8'h06,1'b1}, // R6 sticky
        {2'b00,2'b00,2'b00,2'b00,2'b00,2'b01,2'b00,2'b00,2'b01,8'h02,1'b0}, // R6 clear
        {2'b00,2'b00,2'b10,2'b10,2'b00,2'b00,2'b00,2'b10,2'b00,8'h12,1'b1}, // R7 tx
        {2'b01,2'b01,2'b00,2'b00,2'b00,2'b00,2'b00,2'b10,2'b00,8'h11,1'b1}, // R7 rx
        {2'b00,2'b00,2'b00,2'b11,2'b00,2'b00,2'b00,2'b11,2'b00,8'h01,1'b0}, // R5 R8
        {2'b00,2'b00,2'b00,2'b00,2'b10,2'b00,2'b00,2'b00,2'b10,8'h21,1'b1}, // R6 B brk
        {2'b00,2'b01,2'b00,2'b00,2'b00,2'b10,2'b00,2'b00,2'b10,8'h00,1'b0}  // R2 R6 drain
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drop_pulses();
        rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0; brk_det = '0; brk_clr = '0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        drop_pulses();
        rx_ie = '0; tx_ie = '0; ext_ie = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pend in reset", 32'(pend_stat), 32'h0);
        check("R1 irq in reset", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 brk after reset", 32'(brk_stat), 32'h0);

        for (int i = 0; i < NV; i++) begin
            {rx_set, rx_clr, tx_set, tx_clr, brk_det, brk_clr, rx_ie, tx_ie, ext_ie} = VEC[i][26:9];
            @(posedge clk);
            @(negedge clk);
            check($sformatf("vec %0d pend R2 R3 R4 R5 R6 R7 R10", i), 32'(pend_stat), 32'(VEC[i][8:1]));
            drop_pulses();
            @(posedge clk);
            @(negedge clk);
            check($sformatf("vec %0d irq R8", i), 32'(irq), 32'(VEC[i][0]));
        end

        // R6: break status visible per channel
        brk_det = 2'b10;
        @(posedge clk); @(negedge clk);
        drop_pulses();
        check("R6 brk_stat B", 32'(brk_stat), 32'h2);
        brk_clr = 2'b10;
        @(posedge clk); @(negedge clk);
        drop_pulses();
        check("R6 brk_stat cleared", 32'(brk_stat), 32'h0);

        // R9: irq lags pend_stat by one edge
        rx_ie = 2'b01; tx_ie = '0; ext_ie = '0;
        rx_set = 2'b01;
        @(posedge clk); @(negedge clk);
        drop_pulses();
        check("R9 pend first edge", 32'(pend_stat), 32'h01);
        check("R9 irq still low", 32'(irq), 32'h0);
        @(posedge clk); @(negedge clk);
        check("R9 irq second edge", 32'(irq), 32'h1);

        // R1: reset in mid operation clears everything
        tx_set = 2'b10; brk_det = 2'b01;
        @(posedge clk); @(negedge clk);
        drop_pulses();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 pend after mid reset", 32'(pend_stat), 32'h0);
        check("R1 brk after mid reset", 32'(brk_stat), 32'h0);
        check("R1 irq after mid reset", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule